// File: doc/BRIEF.md
# Slow Bus Half-Word Transfer Port

This block connects a 32-bit register file word to a 16-bit system bus that runs slower than the local clock. On the input side, two bus control lines are sampled on every rising clock edge. One of them acts as the transition line and the other as the background line. A level change on the transition line, seen while the background line is high, captures the 16-bit bus value into one half of a 32-bit input latch:

- A falling change loads the Y half.
- A rising change loads the X half.

An edge-mode input swaps the roles of the two lines. Once a Y half and then an X half have been captured, a ready flag tells the surrounding logic that the storage write may go ahead.

On the output side, a rising slow-read control freezes a fetched 32-bit word in an output register. A half-select input then picks, without any clock delay, which 16-bit half is driven onto the bus. The output stays driven while the slow-read control and the output enable are both high. All transfer logic acts only in wide (32-bit) mode.

Top module: `slow_half_port`

## Requirements
- R1: After reset, `wr_ok_o` is 0, `drive_o` is 0, `bus_data_o` is 0 and `latch_o` is 0.
- R2: With `edge_rise_i`=0 and `wide_i`=1, the transition line is `ctl_hi_i` and the background line is `ctl_lo_i`. A 1-to-0 change of `ctl_hi_i` between two rising edges, with `ctl_lo_i`=1, loads `bus_data_i` into the Y half, `latch_o[15:0]`, at the second edge.
- R3: In the same setup, a 0-to-1 change of the transition line loads `bus_data_i` into the X half, `latch_o[31:16]`.
- R4: A transition is ignored, leaving `latch_o` and `wr_ok_o` unchanged, when the background line is 0 or `wide_i` is 0.
- R5: With `edge_rise_i`=1 the roles swap: `ctl_lo_i` is the transition line and `ctl_hi_i` the background line. Changes on `ctl_hi_i` then load nothing.
- R6: With no transition, `latch_o` keeps its value whatever `bus_data_i` does. The first rising edge after reset never counts as a transition.
- R7: `wr_ok_o` goes to 1 at the edge that loads an X half after a Y half. A later Y load clears it.
- R8: A 0-to-1 change of `slow_rd_i` with `wide_i`=1 captures `rd_word_i` at that edge. The captured word is held while `slow_rd_i` stays 1, even if `rd_word_i` changes.
- R9: `half_sel_i` selects the driven half combinationally: 0 gives bits [15:0] (Y) and 1 gives bits [31:16] (X).
- R10: `drive_o` is 1 exactly when `slow_rd_i`, `out_en_i` and `wide_i` are all 1. When `drive_o` is 0, `bus_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_i | input | 1 | Wide (32-bit) mode enable |
| edge_rise_i | input | 1 | Edge mode: 0 makes ctl_hi_i the transition line, 1 makes ctl_lo_i the transition line |
| ctl_hi_i | input | 1 | Load control line A |
| ctl_lo_i | input | 1 | Load control line B |
| bus_data_i | input | 16 | Bus data in |
| slow_rd_i | input | 1 | Slow-read control |
| half_sel_i | input | 1 | Half select for the output |
| out_en_i | input | 1 | Output enable |
| rd_word_i | input | 32 | Fetched word from storage |
| latch_o | output | 32 | Assembled input word {X, Y} |
| wr_ok_o | output | 1 | Both halves loaded |
| bus_data_o | output | 16 | Bus data out |
| drive_o | output | 1 | Bus driven |

## Verification
The assertions assume the control lines and the bus data are stable around each rising edge. They also assume the edge mode is not changed while a half transfer is in progress, so that a level difference between two samples of the same line is a real bus transition. The bench changes all inputs only at falling clock edges, moves at most one transition line per cycle, and sets the edge mode while both lines are held steady.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int unsigned HALF_W_DEF = 16;
  localparam int unsigned N_HALF     = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;

  typedef enum logic [0:0] {
    HALF_Y = 1'b0,
    HALF_X = 1'b1
  } half_e;
endpackage

// File: rtl/spt_ctl_sampler.sv
module spt_ctl_sampler
  import spt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wide_i,
  input  logic edge_rise_i,
  input  logic ctl_hi_i,
  input  logic ctl_lo_i,
  output logic ld_y_o,
  output logic ld_x_o
);
  logic hi_q, lo_q, seen_q;
  logic trans_now, trans_prev, bg_now, hit;
  edge_mode_e mode;

  assign mode = edge_mode_e'(edge_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hi_q   <= ctl_hi_i;
      lo_q   <= ctl_lo_i;
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    if (mode == EDGE_RISE) begin
      trans_now  = ctl_lo_i;
      trans_prev = lo_q;
      bg_now     = ctl_hi_i;
    end else begin
      trans_now  = ctl_hi_i;
      trans_prev = hi_q;
      bg_now     = ctl_lo_i;
    end
  end

  // first edge after reset has no valid prior sample
  assign hit    = seen_q & wide_i & bg_now & (trans_now ^ trans_prev);
  assign ld_y_o = hit & ~trans_now;
  assign ld_x_o = hit &  trans_now;
endmodule

// File: rtl/spt_in_latch.sv
module spt_in_latch
  import spt_pkg::*;
#(
  parameter int unsigned HALF_W = HALF_W_DEF,
  localparam int unsigned WORD_W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HALF-1:0] ld_i,
  input  logic [HALF_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o,
  output logic              wr_ok_o
);
  logic [N_HALF-1:0] got_q;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    logic [HALF_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      half_q <= '0;
      else if (ld_i[h]) half_q <= d_i;
    end
    assign q_o[h*HALF_W +: HALF_W] = half_q;
  end

  // Y starts a new pair, X completes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q <= '0;
    end else if (ld_i[HALF_Y]) begin
      got_q         <= '0;
      got_q[HALF_Y] <= 1'b1;
    end else if (ld_i[HALF_X]) begin
      got_q[HALF_X] <= 1'b1;
    end
  end

  assign wr_ok_o = &got_q;

  assert_y_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i[HALF_Y] |=> q_o[HALF_W-1:0] == $past(d_i));
  assert_x_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i[HALF_X] |=> q_o[WORD_W-1:HALF_W] == $past(d_i));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i == '0) |=> $stable(q_o));
  assert_pair_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ok_o) |-> $past(ld_i[HALF_X]));
endmodule

// File: rtl/spt_out_word.sv
module spt_out_word
  import spt_pkg::*;
#(
  parameter int unsigned HALF_W = HALF_W_DEF,
  localparam int unsigned WORD_W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              slow_rd_i,
  input  logic              half_sel_i,
  input  logic              out_en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [HALF_W-1:0] data_o,
  output logic              drive_o
);
  logic [WORD_W-1:0] word_q;
  logic              rd_q;
  logic              grab;
  half_e             sel;

  assign grab = wide_i & slow_rd_i & ~rd_q;
  assign sel  = half_e'(half_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      word_q <= '0;
    end else begin
      rd_q <= slow_rd_i;
      if (grab) word_q <= word_i;
    end
  end

  // half select bypasses the clock
  assign drive_o = slow_rd_i & out_en_i & wide_i;
  always_comb begin
    data_o = '0;
    if (drive_o) data_o = word_q[sel*HALF_W +: HALF_W];
  end

  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_rd_i && rd_q) |=> $stable(word_q));
  assert_rd_grab_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && slow_rd_i && !rd_q) |=> word_q == $past(word_i));
endmodule

// File: rtl/slow_half_port.sv
module slow_half_port
  import spt_pkg::*;
#(
  parameter int unsigned HALF_W = HALF_W_DEF,
  localparam int unsigned WORD_W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              edge_rise_i,
  input  logic              ctl_hi_i,
  input  logic              ctl_lo_i,
  input  logic [HALF_W-1:0] bus_data_i,
  input  logic              slow_rd_i,
  input  logic              half_sel_i,
  input  logic              out_en_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] latch_o,
  output logic              wr_ok_o,
  output logic [HALF_W-1:0] bus_data_o,
  output logic              drive_o
);
  logic [N_HALF-1:0] ld;

  spt_ctl_sampler u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wide_i      (wide_i),
    .edge_rise_i (edge_rise_i),
    .ctl_hi_i    (ctl_hi_i),
    .ctl_lo_i    (ctl_lo_i),
    .ld_y_o      (ld[HALF_Y]),
    .ld_x_o      (ld[HALF_X])
  );

  spt_in_latch #(.HALF_W(HALF_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ld),
    .d_i     (bus_data_i),
    .q_o     (latch_o),
    .wr_ok_o (wr_ok_o)
  );

  spt_out_word #(.HALF_W(HALF_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wide_i     (wide_i),
    .slow_rd_i  (slow_rd_i),
    .half_sel_i (half_sel_i),
    .out_en_i   (out_en_i),
    .word_i     (rd_word_i),
    .data_o     (bus_data_o),
    .drive_o    (drive_o)
  );

  assert_no_stray_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> $stable(latch_o));
endmodule

// File: tb/slow_half_port_tb.sv
module slow_half_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide = 1'b0, edge_rise = 1'b0, ctl_hi = 1'b0, ctl_lo = 1'b0;
  logic [15:0] bus_in = '0;
  logic        slow_rd = 1'b0, half_sel = 1'b0, out_en = 1'b0;
  logic [31:0] rd_word = '0;
  logic [31:0] latch;
  logic        wr_ok, drive;
  logic [15:0] bus_out;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  slow_half_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .edge_rise_i(edge_rise),
    .ctl_hi_i(ctl_hi), .ctl_lo_i(ctl_lo), .bus_data_i(bus_in),
    .slow_rd_i(slow_rd), .half_sel_i(half_sel), .out_en_i(out_en),
    .rd_word_i(rd_word), .latch_o(latch), .wr_ok_o(wr_ok),
    .bus_data_o(bus_out), .drive_o(drive)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 wr_ok", 32'(wr_ok), 32'd0);
    chk("R1 drive", 32'(drive), 32'd0);
    chk("R1 bus_out", 32'(bus_out), 32'd0);
    chk("R1 latch", latch, 32'd0);
  endtask

  task automatic t_fall_y();
    wide = 1; edge_rise = 0; ctl_hi = 1; ctl_lo = 1; step();
    chk("R6 first edge no load", latch, 32'd0);
    bus_in = 16'hA5C3; ctl_hi = 0; step();
    chk("R2 Y load", latch, 32'h0000_A5C3);
    bus_in = 16'hFFFF; step();
    chk("R6 hold", latch, 32'h0000_A5C3);
    chk("R7 not ready after Y", 32'(wr_ok), 32'd0);
  endtask

  task automatic t_fall_x();
    bus_in = 16'h1234; ctl_hi = 1; step();
    chk("R3 X load", latch, 32'h1234_A5C3);
    chk("R7 ready", 32'(wr_ok), 32'd1);
  endtask

  task automatic t_ignore();
    ctl_lo = 0; step();
    bus_in = 16'h0BAD; ctl_hi = 0; step();
    chk("R4 background low", latch, 32'h1234_A5C3);
    chk("R4 wr_ok kept", 32'(wr_ok), 32'd1);
    wide = 0; ctl_lo = 1; ctl_hi = 1; step();
    ctl_hi = 0; step();
    chk("R4 narrow mode", latch, 32'h1234_A5C3);
    wide = 1; step();
  endtask

  task automatic t_rise();
    edge_rise = 1; ctl_hi = 1; ctl_lo = 1; step();
    bus_in = 16'h7E57; ctl_lo = 0; step();
    chk("R5 Y load rise mode", latch, 32'h1234_7E57);
    chk("R7 cleared by Y", 32'(wr_ok), 32'd0);
    bus_in = 16'hC0DE; ctl_lo = 1; step();
    chk("R5 X load rise mode", latch, 32'hC0DE_7E57);
    chk("R7 ready again", 32'(wr_ok), 32'd1);
    bus_in = 16'h5555; ctl_hi = 0; step();
    ctl_hi = 1; step();
    chk("R5 hi line ignored", latch, 32'hC0DE_7E57);
  endtask

  task automatic t_slow_read();
    rd_word = 32'hDEAD_BEEF; slow_rd = 1; out_en = 1; half_sel = 0; step();
    chk("R8 capture Y half", 32'(bus_out), 32'h0000_BEEF);
    chk("R10 driven", 32'(drive), 32'd1);
    rd_word = 32'h1111_2222; step();
    chk("R8 frozen", 32'(bus_out), 32'h0000_BEEF);
    half_sel = 1; #1;
    chk("R9 X half", 32'(bus_out), 32'h0000_DEAD);
    out_en = 0; #1;
    chk("R10 disabled", 32'(drive), 32'd0);
    chk("R10 zero data", 32'(bus_out), 32'd0);
    out_en = 1; half_sel = 0;
    slow_rd = 0; step();
    rd_word = 32'h3333_4444; slow_rd = 1; step();
    chk("R8 recapture", 32'(bus_out), 32'h0000_4444);
    wide = 0; #1;
    chk("R10 narrow no drive", 32'(drive), 32'd0);
    wide = 1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_fall_y();
    t_fall_x();
    t_ignore();
    t_rise();
    t_slow_read();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule